// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate, an interrupt number and a priority, and the block registers that offer. The block raises a request line to the processor only when several things hold at once. Signalling must be switched on. The candidate priority must be numerically below a programmable threshold. The interrupt number must be one of the usable ones. No earlier interrupt may still be in service.

Software reaches the block through four word registers, selected by a 2-bit address. They are an enable, the priority threshold, an acknowledge register and a completion register. Reading the acknowledge register claims the offered interrupt: it returns the number, marks it as in service and pulses that number to the distributor so it can clear pending and set active. When nothing qualifies, the read returns the reserved number 1023 and changes nothing. Writing the same number to the completion register later retires it and pulses it to the distributor. A completion with any other number is dropped. Only one interrupt can be in service at a time.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the request line is low, the enable register reads 0, the threshold reads 0x00, no interrupt is in service and an acknowledge read returns 1023.
- R2: The request line is high exactly when signalling is enabled, the registered candidate is valid, its number is below 1020, its priority is numerically less than the threshold and nothing is in service. The candidate inputs take effect one clock after they are applied.
- R3: An acknowledge read (address 2) while the request line is high returns the candidate number in bits 9:0 with all upper bits zero. The block marks that number in service and pulses ack_valid for one cycle with ack_id equal to it.
- R4: An acknowledge read while the request line is low returns 1023, gives no ack_valid pulse and leaves the in-service state unchanged.
- R5: While enable bit 0 (address 0) is 0, the request line stays low and acknowledge reads return 1023, whatever the candidate and threshold.
- R6: Candidate numbers 1020, 1021, 1022 and 1023 are never signalled or returned, and 1019 is.
- R7: After a successful acknowledge read the request line is low in the next cycle. It stays low for every candidate until the matching completion.
- R8: A write to the completion register (address 3) whose bits 9:0 equal the in-service number ends service and pulses eoi_valid for one cycle with eoi_id equal to that number.
- R9: A completion write with a number that differs from the in-service number, or with nothing in service, is ignored. No eoi_valid pulse follows and the interrupt stays in service.
- R10: Address 0 reads back the enable in bit 0 and address 1 reads back the 8-bit threshold, both zero-extended. Address 3 reads as 0. A write to address 2 changes no state.
- R11: A candidate whose priority equals the threshold is not signalled, and one whose priority is one below the threshold is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Offered interrupt number |
| cand_prio | input | 8 | Offered priority, lower value is more urgent |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 threshold, 2 acknowledge, 3 completion |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | One-cycle pulse: an interrupt was claimed |
| ack_id | output | 10 | Number claimed |
| eoi_valid | output | 1 | One-cycle pulse: an interrupt was retired |
| eoi_id | output | 10 | Number retired |

## Verification
The bench builds the block with its default widths: 10-bit numbers, 8-bit priorities and a 32-bit register word. With these widths the reserved band 1020 to 1023 and the last usable number 1019 can be offered directly, and so can both priority extremes, 0x00 and 0xFF, against any threshold. Random candidates cover the whole 10-bit space, so the reserved band recurs during the random phase. Mismatched completions come up naturally because the completion data is often drawn at random.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [PRIO_W-1:0] prio_t;

    // All-ones number is the "nothing to claim" answer; the three below it are reserved too.
    localparam irq_id_t SPURIOUS_ID = '1;
    localparam irq_id_t ID_LIMIT    = SPURIOUS_ID - irq_id_t'(3);

    typedef struct packed {
        logic    valid;
        irq_id_t id;
        prio_t   prio;
    } cand_t;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_MASK = 2'd1,
        SEL_ACK  = 2'd2,
        SEL_EOI  = 2'd3
    } reg_sel_e;

    function automatic logic cand_passes(cand_t c, logic en, prio_t thresh);
        return en && c.valid && (c.id < ID_LIMIT) && (c.prio < thresh);
    endfunction

endpackage

// File: rtl/cpuif_cand.sv
module cpuif_cand
    import cpuif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  irq_id_t in_id,
    input  prio_t   in_prio,
    output cand_t   cand
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cand <= '0;
        end else begin
            cand.valid <= in_valid;
            cand.id    <= in_id;
            cand.prio  <= in_prio;
        end
    end

endmodule

// File: rtl/cpuif_regs.sv
module cpuif_regs
    import cpuif_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic              wr_en_bit,
    input  prio_t             wr_mask,
    output logic              en,
    output prio_t             mask,
    output logic [DATA_W-1:0] rd_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            mask <= '0;
        end else if (wr) begin
            if (sel == SEL_CTRL) en   <= wr_en_bit;
            if (sel == SEL_MASK) mask <= wr_mask;
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rd_val = DATA_W'(en);
            SEL_MASK: rd_val = DATA_W'(mask);
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/cpuif_ack.sv
module cpuif_ack
    import cpuif_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cand_t   cand,
    input  logic    en,
    input  prio_t   mask,
    input  logic    ack_rd,
    input  logic    eoi_wr,
    input  irq_id_t eoi_in,
    output logic    irq,
    output irq_id_t ack_result,
    output logic    ack_valid,
    output irq_id_t ack_id,
    output logic    eoi_valid,
    output irq_id_t eoi_id
);

    logic    act_v;
    irq_id_t act_id;
    logic    eligible;
    logic    eoi_hit;

    assign eligible   = cand_passes(cand, en, mask) && !act_v;
    assign irq        = eligible;
    assign ack_result = eligible ? cand.id : SPURIOUS_ID;
    assign eoi_hit    = eoi_wr && act_v && (eoi_in == act_id);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_v     <= 1'b0;
            act_id    <= '0;
            ack_valid <= 1'b0;
            ack_id    <= '0;
            eoi_valid <= 1'b0;
            eoi_id    <= '0;
        end else begin
            ack_valid <= ack_rd && eligible;
            eoi_valid <= 1'b0;
            if (ack_rd && eligible) begin
                ack_id <= cand.id;
                act_v  <= 1'b1;
                act_id <= cand.id;
            end else if (eoi_hit) begin
                act_v     <= 1'b0;
                eoi_valid <= 1'b1;
                eoi_id    <= act_id;
            end
        end
    end

    // R7: a claim in the previous cycle leaves the request line low now
    a_r7_low_after_claim: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !irq);

    // R7: service only starts from a raised request
    a_r7_claim_from_request: assert property (@(posedge clk) disable iff (rst)
        $rose(act_v) |-> $past(irq));

    // R6: a claimed number is always below the reserved band
    a_r6_claim_in_range: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (ack_id < ID_LIMIT));

    // R8: a retirement pulse names what was in service
    a_r8_retire_matches: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> ($past(act_v) && eoi_id == $past(act_id)));

    // R9: a mismatched completion keeps the interrupt in service
    a_r9_mismatch_kept: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && act_v && eoi_in != act_id) |=> (act_v && !eoi_valid));

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpuif_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_valid,
    output logic [ID_W-1:0]   eoi_id
);

    reg_sel_e          sel;
    cand_t             cand;
    logic              en;
    prio_t             mask;
    logic [DATA_W-1:0] cfg_rd;
    irq_id_t           ack_result;
    logic              unused_wdata;

    assign sel          = reg_sel_e'(reg_addr);
    assign unused_wdata = ^reg_wdata[DATA_W-1:ID_W];

    cpuif_cand u_cand (
        .clk      (clk),
        .rst      (rst),
        .in_valid (cand_valid),
        .in_id    (cand_id),
        .in_prio  (cand_prio),
        .cand     (cand)
    );

    cpuif_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .sel       (sel),
        .wr_en_bit (reg_wdata[0]),
        .wr_mask   (reg_wdata[PRIO_W-1:0]),
        .en        (en),
        .mask      (mask),
        .rd_val    (cfg_rd)
    );

    cpuif_ack u_ack (
        .clk        (clk),
        .rst        (rst),
        .cand       (cand),
        .en         (en),
        .mask       (mask),
        .ack_rd     (reg_rd && sel == SEL_ACK),
        .eoi_wr     (reg_wr && sel == SEL_EOI),
        .eoi_in     (reg_wdata[ID_W-1:0]),
        .irq        (irq_out),
        .ack_result (ack_result),
        .ack_valid  (ack_valid),
        .ack_id     (ack_id),
        .eoi_valid  (eoi_valid),
        .eoi_id     (eoi_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= (sel == SEL_ACK) ? DATA_W'(ack_result) : cfg_rd;
        end
    end

    // R5: disabled signalling keeps the request line low
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |-> !irq_out);

    // R11: a raised request always carries a priority under the threshold
    a_r11_below_threshold: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (cand.prio < mask));

    // R3: a claim pulse follows a read of the acknowledge address
    a_r3_claim_from_read: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(reg_rd && reg_addr == 2'd2));

endmodule

// File: tb/cpu_irq_iface_test.sv
module cpu_irq_iface_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        cand_valid;
    logic [9:0]  cand_id;
    logic [7:0]  cand_prio;
    logic        reg_wr;
    logic        reg_rd;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic        ack_valid;
    logic [9:0]  ack_id;
    logic        eoi_valid;
    logic [9:0]  eoi_id;

    always #5 clk = ~clk;

    cpu_irq_iface uut (
        .clk(clk), .rst(rst),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // reference model state
    bit       m_en, m_cv, m_act;
    bit [9:0] m_cid, m_aid;
    bit [7:0] m_cp, m_mask;

    function automatic bit exp_irq();
        return m_en && m_cv && (m_cid < 10'd1020) && (m_cp < m_mask) && !m_act;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put_cand(bit v, bit [9:0] id, bit [7:0] p);
        cand_valid = v; cand_id = id; cand_prio = p;
        tick();
        m_cv = v; m_cid = id; m_cp = p;
        check("R2 irq after candidate", int'(irq_out), int'(exp_irq()));
    endtask

    task automatic wr_reg(bit [1:0] a, bit [31:0] d);
        bit hit;
        hit = m_act && (d[9:0] == m_aid);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        case (a)
            2'd0: m_en = d[0];
            2'd1: m_mask = d[7:0];
            2'd3: begin
                check("R8/R9 eoi pulse", int'(eoi_valid), int'(hit));
                if (hit) begin
                    check("R8 eoi id", int'(eoi_id), int'(m_aid));
                    m_act = 0;
                end
            end
            default: ;
        endcase
        check("R2 irq after write", int'(irq_out), int'(exp_irq()));
    endtask

    task automatic rd_reg(bit [1:0] a, output bit [31:0] v);
        bit elig;
        bit [31:0] e;
        elig = exp_irq();
        case (a)
            2'd0: e = {31'd0, m_en};
            2'd1: e = {24'd0, m_mask};
            2'd2: e = elig ? {22'd0, m_cid} : 32'd1023;
            default: e = 32'd0;
        endcase
        reg_rd = 1'b1; reg_addr = a;
        tick();
        reg_rd = 1'b0;
        v = reg_rdata;
        check("R10/R3/R4 read data", int'(reg_rdata), int'(e));
        check("R3/R4 ack pulse", int'(ack_valid), int'(a == 2'd2 && elig));
        if (a == 2'd2 && elig) begin
            check("R3 ack id", int'(ack_id), int'(m_cid));
            m_act = 1; m_aid = m_cid;
        end
        check("R7 irq after read", int'(irq_out), int'(exp_irq()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit [31:0] v;
        void'($urandom(32'd1234));
        rst = 1'b1; cand_valid = 0; cand_id = 0; cand_prio = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        m_en = 0; m_cv = 0; m_act = 0; m_cid = 0; m_aid = 0; m_cp = 0; m_mask = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1 irq low", int'(irq_out), 0);
        rd_reg(2'd0, v);
        rd_reg(2'd1, v);
        rd_reg(2'd2, v);
        check("R1 ack spurious", int'(v), 1023);

        // R5 disabled: threshold open, still quiet
        put_cand(1, 10'd37, 8'hA0);
        wr_reg(2'd1, 32'hF0);
        check("R5 irq low disabled", int'(irq_out), 0);
        rd_reg(2'd2, v);
        check("R5 ack spurious", int'(v), 1023);

        // R2 / R3 / R7 claim
        wr_reg(2'd0, 32'd1);
        check("R2 irq high", int'(irq_out), 1);
        rd_reg(2'd2, v);
        check("R3 claim value", int'(v), 37);
        check("R7 irq dropped", int'(irq_out), 0);
        put_cand(1, 10'd50, 8'h10);
        check("R7 held low in service", int'(irq_out), 0);
        rd_reg(2'd2, v);
        check("R4 spurious in service", int'(v), 1023);

        // R9 mismatched completion, then R8 matching
        wr_reg(2'd3, 32'd50);
        check("R9 still in service", int'(irq_out), 0);
        wr_reg(2'd3, 32'd37);
        check("R8 released", int'(irq_out), 1);
        rd_reg(2'd2, v);
        wr_reg(2'd3, 32'd50);
        wr_reg(2'd3, 32'd50);   // R9 nothing in service

        // R6 boundary numbers
        put_cand(1, 10'd1019, 8'h00);
        rd_reg(2'd2, v);
        check("R6 1019 claimed", int'(v), 1019);
        wr_reg(2'd3, 32'd1019);
        for (int k = 1020; k < 1024; k++) begin
            put_cand(1, 10'(k), 8'h00);
            check("R6 reserved quiet", int'(irq_out), 0);
            rd_reg(2'd2, v);
            check("R6 reserved spurious", int'(v), 1023);
        end

        // R11 threshold edge
        put_cand(1, 10'd5, 8'hF0);
        check("R11 equal not signalled", int'(irq_out), 0);
        put_cand(1, 10'd5, 8'hEF);
        check("R11 one below signalled", int'(irq_out), 1);
        wr_reg(2'd1, 32'h00);
        put_cand(1, 10'd5, 8'h00);
        check("R11 zero threshold", int'(irq_out), 0);

        // R10 write to acknowledge address is ignored; readback widths
        wr_reg(2'd1, 32'hFFFF_FF7C);
        wr_reg(2'd2, 32'hFFFF_FFFF);
        rd_reg(2'd1, v);
        check("R10 mask readback", int'(v), 32'h7C);
        rd_reg(2'd0, v);
        check("R10 ctrl readback", int'(v), 1);
        rd_reg(2'd3, v);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0, 1: put_cand(($urandom % 8) != 0, 10'($urandom), 8'($urandom));
                2: wr_reg(2'd1, $urandom);
                3: wr_reg(2'd0, ($urandom % 4) != 0 ? 32'd1 : 32'd0);
                4: rd_reg(2'($urandom), v);
                default: wr_reg(2'd3, ($urandom % 2) ? {22'd0, m_aid} : $urandom);
            endcase
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule